// File: doc/BRIEF.md
# Harvester Switch Phase Sequencer

This block drives the gates of the two power switches in one phase of an inductor-based energy converter. A start trigger launches a fixed five-interval cycle. First the low-side switch charges the inductor from the reservoir. Next the high-side switch dumps that energy onto the variable capacitor. Then both switches stay off for a long wait while the capacitor plates move apart. After that the high-side switch recovers the capacitor charge into the inductor. Finally the low-side switch returns the energy to the reservoir. Rectification is done purely by timing, so no diodes and no zero-crossing sensing are needed.

Each interval length is a count of clock cycles taken from a register input, because the component values are known in advance. A programmable dead time separates every handover between the two switches. An interval of length zero is dropped from the cycle. A one-cycle done pulse marks the end of each conversion cycle. The surrounding system raises the trigger once per vibration period.

Top module: `hvs_phase_seq`

## Requirements
- R1: Out of reset, and whenever the block is idle with no trigger, `sw_hi_o`, `sw_lo_o`, `busy_o` and `done_o` are all 0.
- R2: A trigger sampled high at a rising edge while idle starts the cycle at that edge. When `len_charge_i` is nonzero, `sw_lo_o` is 1 (and `sw_hi_o` is 0) for exactly that many cycles, starting in the cycle after that edge.
- R3: The dump interval follows. `sw_hi_o` is 1 and `sw_lo_o` is 0 for exactly `len_dump_i` cycles.
- R4: The wait interval follows. Both gates are 0 and `busy_o` is 1 for exactly `len_wait_i` cycles.
- R5: The recovery interval comes next, with `sw_hi_o` alone on for `len_recover_i` cycles. The return interval follows, with `sw_lo_o` alone on for `len_return_i` cycles.
- R6: When consecutive non-skipped intervals drive different switches, a gap with both gates off and `busy_o` at 1 is inserted between them. The gap lasts `dead_i` cycles, and a `dead_i` of 0 counts as 1. No gap is inserted next to the wait interval or between two intervals that drive the same switch. The two gates are never 1 in the same cycle.
- R7: An interval whose length input is 0 takes no cycles and is skipped entirely.
- R8: `done_o` is 1 for exactly one cycle: the cycle after the last active interval cycle. In that cycle `busy_o` is 0. If all five lengths are 0, the done cycle is the first cycle after the start edge.
- R9: A trigger that arrives while `busy_o` is 1 has no effect on the gate, busy or done waveforms.
- R10: The five lengths are captured at the start edge. Changing the length inputs during a cycle does not change that cycle's timing.
- R11: A trigger sampled in the done cycle starts a new cycle immediately, so cycles can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion start trigger |
| len_charge_i | input | 16 | Inductor charge interval length (cycles) |
| len_dump_i | input | 16 | Dump-to-capacitor interval length (cycles) |
| len_wait_i | input | 16 | Plate-motion wait interval length (cycles) |
| len_recover_i | input | 16 | Recovery-to-inductor interval length (cycles) |
| len_return_i | input | 16 | Return-to-reservoir interval length (cycles) |
| dead_i | input | 3 | Dead time at switch handovers (0 treated as 1) |
| sw_hi_o | output | 1 | High-side switch gate (SW1) |
| sw_lo_o | output | 1 | Low-side switch gate (SW2) |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-cycle end-of-cycle pulse |

## Verification
All outputs are decoded from registered state, so a trigger sampled at edge E first shows its effect in the cycle after E. From then on the bench can predict the value of every output for every cycle. For each start, the bench builds the full per-cycle waveform from the lengths and the dead time: intervals, gaps, skips, and the final done cycle. It queues that waveform, then compares one entry per cycle a quarter period after each rising edge. When the queue is empty it expects the idle outputs. This makes any shift of even one cycle in an interval, a gap or the done pulse show up as a mismatch.

// File: rtl/hvs_pkg.sv
package hvs_pkg;

   localparam int NUM_PHASE = 5;
   localparam int PH_W      = 3;

   typedef enum logic [1:0] {
      OWN_NONE = 2'd0,
      OWN_HI   = 2'd1,
      OWN_LO   = 2'd2
   } own_e;

   typedef enum logic [1:0] {
      MD_IDLE = 2'd0,
      MD_RUN  = 2'd1,
      MD_GAP  = 2'd2
   } mode_e;

   // Which switch a given interval turns on; the order is the conversion order.
   function automatic own_e phase_owner(input logic [PH_W-1:0] idx);
      case (idx)
         3'd0:    return OWN_LO;   // charge inductor
         3'd1:    return OWN_HI;   // dump to capacitor
         3'd3:    return OWN_HI;   // recover into inductor
         3'd4:    return OWN_LO;   // return to reservoir
         default: return OWN_NONE; // plate-motion wait
      endcase
   endfunction

   function automatic logic needs_gap(input own_e a, input own_e b);
      return (a != OWN_NONE) && (b != OWN_NONE) && (a != b);
   endfunction

endpackage

// File: rtl/hvs_len_bank.sv
module hvs_len_bank
   import hvs_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter bit SNAPSHOT = 1'b1
) (
   input  logic                               clk_i,
   input  logic                               rst_ni,
   input  logic                               capture_i,
   input  logic [NUM_PHASE-1:0][CNT_W-1:0]    len_i,
   output logic [NUM_PHASE-1:0][CNT_W-1:0]    len_o
);

   generate
      if (SNAPSHOT) begin : g_snap
         logic [NUM_PHASE-1:0][CNT_W-1:0] held_q;
         for (genvar p = 0; p < NUM_PHASE; p++) begin : g_slot
            always_ff @(posedge clk_i) begin
               if (!rst_ni)        held_q[p] <= '0;
               else if (capture_i) held_q[p] <= len_i[p];
            end
         end
         assign len_o = held_q;
      end else begin : g_live
         logic unused_ctl;
         assign unused_ctl = clk_i ^ rst_ni ^ capture_i;
         assign len_o = len_i;
      end
   endgenerate

endmodule

// File: rtl/hvs_seq_ctrl.sv
module hvs_seq_ctrl
   import hvs_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DEAD_W = 3
) (
   input  logic                            clk_i,
   input  logic                            rst_ni,
   input  logic                            start_i,
   input  logic [NUM_PHASE-1:0][CNT_W-1:0] len_live_i,
   input  logic [NUM_PHASE-1:0][CNT_W-1:0] len_held_i,
   input  logic [DEAD_W-1:0]               dead_i,
   output logic                            capture_o,
   output mode_e                           mode_o,
   output logic [PH_W-1:0]                 phase_o,
   output logic                            done_o
);

   mode_e                           mode_q, mode_d;
   logic [PH_W-1:0]                 ph_q, ph_d, pend_q, pend_d;
   logic [CNT_W-1:0]                cnt_q, cnt_d;
   logic                            done_q, done_d;
   logic [NUM_PHASE-1:0][CNT_W-1:0] lens;
   logic [PH_W:0]                   srch_from;
   logic                            found;
   logic [PH_W-1:0]                 nxt;
   logic [DEAD_W-1:0]               dead_eff;

   assign lens      = (mode_q == MD_IDLE) ? len_live_i : len_held_i;
   assign capture_o = (mode_q == MD_IDLE) && start_i;
   assign dead_eff  = (dead_i == '0) ? DEAD_W'(1) : dead_i;

   // First nonzero interval at or after the search start.
   always_comb begin
      srch_from = (mode_q == MD_IDLE) ? '0 : ({1'b0, ph_q} + 1'b1);
      found     = 1'b0;
      nxt       = '0;
      for (int j = NUM_PHASE - 1; j >= 0; j--) begin
         if ((j >= int'(srch_from)) && (lens[j] != '0)) begin
            found = 1'b1;
            nxt   = PH_W'(j);
         end
      end
   end

   always_comb begin
      mode_d = mode_q;
      ph_d   = ph_q;
      pend_d = pend_q;
      cnt_d  = cnt_q;
      done_d = 1'b0;
      case (mode_q)
         MD_IDLE: begin
            if (start_i) begin
               if (found) begin
                  mode_d = MD_RUN;
                  ph_d   = nxt;
                  cnt_d  = lens[nxt] - 1'b1;
               end else begin
                  done_d = 1'b1;
               end
            end
         end
         MD_RUN: begin
            if (cnt_q != '0) begin
               cnt_d = cnt_q - 1'b1;
            end else if (!found) begin
               mode_d = MD_IDLE;
               done_d = 1'b1;
            end else if (needs_gap(phase_owner(ph_q), phase_owner(nxt))) begin
               mode_d = MD_GAP;
               pend_d = nxt;
               cnt_d  = CNT_W'(dead_eff) - 1'b1;
            end else begin
               ph_d  = nxt;
               cnt_d = lens[nxt] - 1'b1;
            end
         end
         MD_GAP: begin
            if (cnt_q != '0) begin
               cnt_d = cnt_q - 1'b1;
            end else begin
               mode_d = MD_RUN;
               ph_d   = pend_q;
               cnt_d  = lens[pend_q] - 1'b1;
            end
         end
         default: mode_d = MD_IDLE;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         mode_q <= MD_IDLE;
         ph_q   <= '0;
         pend_q <= '0;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         mode_q <= mode_d;
         ph_q   <= ph_d;
         pend_q <= pend_d;
         cnt_q  <= cnt_d;
         done_q <= done_d;
      end
   end

   assign mode_o  = mode_q;
   assign phase_o = ph_q;
   assign done_o  = done_q;

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |=> !done_q); // R8
   AST_DONE_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |-> (mode_q == MD_IDLE)); // R8
   AST_BUSY_IGNORES_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((mode_q == MD_GAP) && start_i) |=> (mode_q == MD_RUN) || (mode_q == MD_GAP)); // R9

endmodule

// File: rtl/hvs_gate_out.sv
module hvs_gate_out
   import hvs_pkg::*;
(
   input  logic            clk_i,
   input  logic            rst_ni,
   input  mode_e           mode_i,
   input  logic [PH_W-1:0] phase_i,
   output logic            sw_hi_o,
   output logic            sw_lo_o,
   output logic            busy_o
);

   own_e own;

   assign own     = phase_owner(phase_i);
   assign sw_hi_o = (mode_i == MD_RUN) && (own == OWN_HI);
   assign sw_lo_o = (mode_i == MD_RUN) && (own == OWN_LO);
   assign busy_o  = (mode_i != MD_IDLE);

   AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(sw_hi_o && sw_lo_o)); // R6
   AST_LO_AFTER_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sw_lo_o) |-> !$past(sw_hi_o)); // R6
   AST_HI_AFTER_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sw_hi_o) |-> !$past(sw_lo_o)); // R6
   AST_IDLE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> (!sw_hi_o && !sw_lo_o)); // R1

endmodule

// File: rtl/hvs_phase_seq.sv
module hvs_phase_seq
   import hvs_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int DEAD_W   = 3,
   parameter bit SNAPSHOT = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  len_charge_i,
   input  logic [CNT_W-1:0]  len_dump_i,
   input  logic [CNT_W-1:0]  len_wait_i,
   input  logic [CNT_W-1:0]  len_recover_i,
   input  logic [CNT_W-1:0]  len_return_i,
   input  logic [DEAD_W-1:0] dead_i,
   output logic              sw_hi_o,
   output logic              sw_lo_o,
   output logic              busy_o,
   output logic              done_o
);

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("hvs_phase_seq: CNT_W must be at least 2");
      end
      if ((DEAD_W < 1) || (DEAD_W > CNT_W)) begin : g_bad_dead
         $error("hvs_phase_seq: DEAD_W must lie in 1..CNT_W");
      end
   endgenerate

   logic [NUM_PHASE-1:0][CNT_W-1:0] len_live, len_held;
   logic                            capture;
   mode_e                           mode;
   logic [PH_W-1:0]                 phase;

   assign len_live = {len_return_i, len_recover_i, len_wait_i, len_dump_i, len_charge_i};

   hvs_len_bank #(.CNT_W(CNT_W), .SNAPSHOT(SNAPSHOT)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .capture_i (capture),
      .len_i     (len_live),
      .len_o     (len_held)
   );

   hvs_seq_ctrl #(.CNT_W(CNT_W), .DEAD_W(DEAD_W)) u_ctrl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (start_i),
      .len_live_i (len_live),
      .len_held_i (len_held),
      .dead_i     (dead_i),
      .capture_o  (capture),
      .mode_o     (mode),
      .phase_o    (phase),
      .done_o     (done_o)
   );

   hvs_gate_out u_gate (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .mode_i  (mode),
      .phase_i (phase),
      .sw_hi_o (sw_hi_o),
      .sw_lo_o (sw_lo_o),
      .busy_o  (busy_o)
   );

endmodule

// File: tb/hvs_phase_seq_tb_top.sv
module hvs_phase_seq_tb_top;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] l_chg = '0, l_dmp = '0, l_wt = '0, l_rec = '0, l_ret = '0;
   logic [2:0]  dead = 3'd1;
   logic        sw_hi, sw_lo, busy, done;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   logic [3:0] exp_q[$];
   string      tag_q[$];

   always #(CLK_P/2) clk = ~clk;

   hvs_phase_seq dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start),
      .len_charge_i(l_chg), .len_dump_i(l_dmp), .len_wait_i(l_wt),
      .len_recover_i(l_rec), .len_return_i(l_ret), .dead_i(dead),
      .sw_hi_o(sw_hi), .sw_lo_o(sw_lo), .busy_o(busy), .done_o(done)
   );

   task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: hi/lo/busy/done got %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // Build the expected per-cycle waveform of one cycle from the requirements.
   task automatic push_expect(input logic [15:0] l0, l1, l2, l3, l4, input logic [2:0] d);
      logic [15:0] l[5];
      int own[5];
      int prev;
      int de;
      l[0] = l0; l[1] = l1; l[2] = l2; l[3] = l3; l[4] = l4;
      own[0] = 2; own[1] = 1; own[2] = 0; own[3] = 1; own[4] = 2; // 1 = hi, 2 = lo
      de = (d == 3'd0) ? 1 : int'(d);
      prev = 0;
      for (int i = 0; i < 5; i++) begin
         if (l[i] != 16'd0) begin // R7: zero-length intervals add nothing
            if (prev != 0 && own[i] != 0 && prev != own[i]) begin
               for (int k = 0; k < de; k++) begin
                  exp_q.push_back(4'b0010); tag_q.push_back("R6");
               end
            end
            for (int k = 0; k < int'(l[i]); k++) begin
               exp_q.push_back({own[i] == 1, own[i] == 2, 1'b1, 1'b0});
               case (i)
                  0: tag_q.push_back("R2");
                  1: tag_q.push_back("R3");
                  2: tag_q.push_back("R4");
                  default: tag_q.push_back("R5");
               endcase
            end
            prev = own[i];
         end
      end
      exp_q.push_back(4'b0001); tag_q.push_back("R8");
   endtask

   task automatic set_lens(input logic [15:0] l0, l1, l2, l3, l4, input logic [2:0] d);
      l_chg = l0; l_dmp = l1; l_wt = l2; l_rec = l3; l_ret = l4; dead = d;
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic run_seq(input logic [15:0] l0, l1, l2, l3, l4, input logic [2:0] d);
      @(negedge clk);
      set_lens(l0, l1, l2, l3, l4, d);
      push_expect(l0, l1, l2, l3, l4, d);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      drain();
   endtask

   // Monitor: one comparison a quarter period after each rising edge.
   initial begin
      forever begin
         @(posedge clk);
         #(CLK_P/4);
         if (rst_n && !finished) begin
            if (exp_q.size() != 0) begin
               check(tag_q.pop_front(), {sw_hi, sw_lo, busy, done}, exp_q.pop_front());
            end else begin
               check("R1", {sw_hi, sw_lo, busy, done}, 4'b0000);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", {sw_hi, sw_lo, busy, done}, 4'b0000); // outputs held low in reset
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      run_seq(16'd4, 16'd3, 16'd5, 16'd2, 16'd3, 3'd2);   // R2 R3 R4 R5 R6 basic
      run_seq(16'd2, 16'd2, 16'd1, 16'd2, 16'd2, 3'd0);   // R6 dead 0 acts as 1
      run_seq(16'd1, 16'd1, 16'd3, 16'd1, 16'd1, 3'd7);   // R6 widest gap
      run_seq(16'd3, 16'd0, 16'd0, 16'd4, 16'd2, 3'd3);   // R7 lo->hi across skips
      run_seq(16'd3, 16'd2, 16'd0, 16'd2, 16'd3, 3'd2);   // R7 hi->hi no gap
      run_seq(16'd2, 16'd3, 16'd0, 16'd0, 16'd2, 3'd1);   // R7 hi->lo gap
      run_seq(16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 3'd2);   // R8 all zero: done only
      run_seq(16'd0, 16'd0, 16'd6, 16'd0, 16'd0, 3'd2);   // R7 wait only
      run_seq(16'd5, 16'd4, 16'd300, 16'd4, 16'd5, 3'd4); // R4 long wait

      // R9: trigger during the wait interval is ignored.
      @(negedge clk);
      set_lens(16'd3, 16'd2, 16'd40, 16'd2, 16'd3, 3'd2);
      push_expect(16'd3, 16'd2, 16'd40, 16'd2, 16'd3, 3'd2);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (15) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      drain();

      // R10: length inputs change mid-cycle with no effect.
      @(negedge clk);
      set_lens(16'd4, 16'd2, 16'd6, 16'd3, 16'd2, 3'd2);
      push_expect(16'd4, 16'd2, 16'd6, 16'd3, 16'd2, 3'd2);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      set_lens(16'd9, 16'd0, 16'd1, 16'd0, 16'd9, 3'd2);
      drain();

      // R11: trigger held high, second cycle starts in the done cycle.
      begin
         int t;
         @(negedge clk);
         set_lens(16'd2, 16'd2, 16'd3, 16'd2, 16'd2, 3'd1);
         push_expect(16'd2, 16'd2, 16'd3, 16'd2, 16'd2, 3'd1);
         t = exp_q.size();
         push_expect(16'd2, 16'd2, 16'd3, 16'd2, 16'd2, 3'd1);
         start = 1'b1;
         repeat (t + 1) @(negedge clk);
         start = 1'b0;
         drain();
      end

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule